// File: doc/BRIEF.md
# Fault Policy Controller

This block sits beside a multi-rail power sequencer and decides what happens when a rail goes wrong. For each rail it watches four fault causes: over-voltage, a two-level thermal input, under-voltage and start-up timeout. When a rail first shows a cause, that is a fault event. The block keeps only the most severe cause present at that moment and applies one system-wide policy. Under latch-off it holds the rails down until a manual clear. Under auto-retry it holds them down for a back-off period and then asks for a restart. The number of retries is capped, and once the cap is used up it falls back to latch-off.

Every fault event pulses a fault pin and updates a small log for its rail. The log holds the last cause, a saturating occurrence count and a status. For each rail the block also measures, in millisecond ticks, how long the rail took from enable to power-good on its most recent start.

The system reset output is released only while the controller is running, every rail is good, and a release delay has run out. A watchdog bark pulls the reset low and restarts the release delay, so it cannot release reset early.

The controller has four states:
- `ST_WAIT`: waiting for all rails to become good after power-up or a restart.
- `ST_RUN`: normal operation.
- `ST_BACKOFF`: rails held off while the back-off timer runs.
- `ST_LATCHED`: rails held off until a manual clear.

The transitions are:
- WAIT→RUN: all rails good and no event.
- WAIT/RUN→LATCHED: an event arrives under latch-off, or with the retry budget spent.
- WAIT/RUN→BACKOFF: an event arrives under auto-retry with budget left.
- BACKOFF→BACKOFF: an event arrives; one attempt is charged and the timer restarts.
- BACKOFF→LATCHED: an event uses the last attempt.
- BACKOFF→WAIT: the timer expires; a restart pulse is issued and one attempt is charged.
- LATCHED→WAIT: manual clear; a restart pulse is issued.

Top module: `fault_policy_ctrl`

## Requirements
- R1: At a fault event the logged cause is the most severe cause active on that rail, in the order OV > thermal-critical > UV > timeout. The 2-bit cause code is 3 for OV, 2 for thermal, 1 for UV and 0 for timeout.
- R2: Each rail's thermal input is a 2-bit level: 0 means normal, 1 means warning, and 2 or 3 mean critical. A warning alone raises no event, leaves `fault_pin` low and leaves the log unchanged.
- R3: With `pol_retry`=0, an event sets `shut_req` high from the next cycle. `shut_req` stays high until `man_clr`. In the cycle after the clear, `shut_req` is low and `restart_req` pulses for one cycle.
- R4: With `pol_retry`=1, an event in WAIT or RUN holds `shut_req` high for exactly BACKOFF_CYC cycles. When it drops, `restart_req` pulses for one cycle and the controller re-enters WAIT. WAIT moves to RUN once all rails are good.
- R5: After the RETRY_CAP-th charged attempt, a further failure moves the controller to LATCHED and it stays there until `man_clr`.
- R6: An event during back-off charges one attempt and restarts the back-off timer, so `shut_req` then stays high for another full BACKOFF_CYC cycles.
- R7: Every event pulses `fault_pin` high for one cycle, in the cycle after the event. It also raises the rail's occurrence count by one; the count saturates at 2^CNT_W−1.
- R8: Status codes are 0 for OK, 1 for latched and 2 for retrying. An event sets its rail to latched if the controller enters LATCHED, and to retrying otherwise. Entering LATCHED turns any retrying rail into latched. Entering RUN, or leaving LATCHED through a clear, sets every rail to OK.
- R9: For each rail, `log_pg_ms` records the `ms_tick` pulses counted while the rail is enabled and not yet good. The value is stored when power-good rises and saturates at 2^MS_W−1.
- R10: `sys_rst_n` is high only in RUN after all rails have stayed good for REL_CYC cycles. A `wdt_bark` drives it low in the next cycle and restarts the delay.
- R11: `man_clr` zeroes the retry budget in any state and keeps the occurrence counts.
- R12: After reset the controller is in WAIT. All outputs are low and every log field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_retry | input | 1 | Selects the policy: 1 for auto-retry, 0 for latch-off |
| man_clr | input | 1 | Manual clear |
| wdt_bark | input | 1 | Watchdog expiry pulse from software supervision |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| rail_en | input | N_RAILS | Per-rail enable from the sequencer |
| rail_pg | input | N_RAILS | Per-rail power-good |
| flt_ov | input | N_RAILS | Per-rail over-voltage fault |
| flt_therm | input | 2*N_RAILS | Per-rail thermal level |
| flt_uv | input | N_RAILS | Per-rail under-voltage fault |
| flt_tmo | input | N_RAILS | Per-rail start-up timeout |
| shut_req | output | 1 | Asks the sequencer to hold the rails off |
| restart_req | output | 1 | One-cycle request to restart the sequence |
| fault_pin | output | 1 | Fault pulse |
| sys_rst_n | output | 1 | System reset, active low |
| log_type | output | 2*N_RAILS | Last cause code for each rail |
| log_count | output | CNT_W*N_RAILS | Occurrence count for each rail |
| log_status | output | 2*N_RAILS | Status code for each rail |
| log_pg_ms | output | MS_W*N_RAILS | Enable-to-good time for each rail |

## Verification
The properties assume that an event is the rising edge of a rail's combined fault level, and that REL_CYC and RETRY_CAP are at least 1. They also assume that `man_clr` never arrives in the same cycle as a fault event. The stimulus drives faults as single-cycle pulses separated by idle cycles, so every pulse is a distinct event. It keeps `man_clr` apart from fault pulses. It moves the power-good inputs only at chosen points, so that WAIT either advances at once or stays put on purpose.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_RUN     = 2'd1,
        ST_BACKOFF = 2'd2,
        ST_LATCHED = 2'd3
    } fpc_state_t;

    typedef enum logic [1:0] {
        FK_TMO   = 2'd0,
        FK_UV    = 2'd1,
        FK_THERM = 2'd2,
        FK_OV    = 2'd3
    } fault_kind_t;

    localparam logic [1:0] STS_OK      = 2'd0;
    localparam logic [1:0] STS_LATCHED = 2'd1;
    localparam logic [1:0] STS_RETRY   = 2'd2;
endpackage

// File: rtl/fpc_coalesce.sv
module fpc_coalesce
    import fpc_pkg::*;
#(
    parameter int N_RAILS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_RAILS-1:0]   flt_ov,
    input  logic [2*N_RAILS-1:0] flt_therm,
    input  logic [N_RAILS-1:0]   flt_uv,
    input  logic [N_RAILS-1:0]   flt_tmo,
    output logic [N_RAILS-1:0]   evt,
    output logic [2*N_RAILS-1:0] kind
);
    for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
        logic        crit;
        logic        active;
        logic        active_q;
        fault_kind_t kind_r;

        assign crit   = flt_therm[2*r +: 2] > 2'd1;
        assign active = flt_ov[r] | crit | flt_uv[r] | flt_tmo[r];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) active_q <= 1'b0;
            else        active_q <= active;
        end

        always_comb begin
            if (flt_ov[r])      kind_r = FK_OV;
            else if (crit)      kind_r = FK_THERM;
            else if (flt_uv[r]) kind_r = FK_UV;
            else                kind_r = FK_TMO;
        end

        assign evt[r]          = active & ~active_q;
        assign kind[2*r +: 2]  = kind_r;
    end
endmodule

// File: rtl/fpc_pgtime.sv
module fpc_pgtime #(
    parameter int N_RAILS = 4,
    parameter int MS_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ms_tick,
    input  logic [N_RAILS-1:0]      rail_en,
    input  logic [N_RAILS-1:0]      rail_pg,
    output logic [MS_W*N_RAILS-1:0] pg_ms
);
    for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
        logic [MS_W-1:0] run_cnt;
        logic [MS_W-1:0] stored;
        logic            pg_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_cnt <= '0;
                stored  <= '0;
                pg_q    <= 1'b0;
            end else begin
                pg_q <= rail_pg[r];
                if (!rail_en[r])
                    run_cnt <= '0;
                else if (!rail_pg[r] && ms_tick && run_cnt != '1)
                    run_cnt <= run_cnt + 1'b1;
                if (rail_en[r] && rail_pg[r] && !pg_q)
                    stored <= run_cnt;
            end
        end

        assign pg_ms[MS_W*r +: MS_W] = stored;
    end
endmodule

// File: rtl/fpc_fsm.sv
module fpc_fsm
    import fpc_pkg::*;
#(
    parameter int RETRY_CAP   = 3,
    parameter int BACKOFF_CYC = 1000,
    parameter int REL_CYC     = 200,
    localparam int RETRY_W    = $clog2(RETRY_CAP + 1),
    localparam int TMR_W      = $clog2(BACKOFF_CYC + 1),
    localparam int REL_W      = $clog2(REL_CYC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pol_retry,
    input  logic               man_clr,
    input  logic               wdt_bark,
    input  logic               all_good,
    input  logic               any_evt,
    output fpc_state_t         state,
    output fpc_state_t         nxt,
    output logic [RETRY_W-1:0] retry_cnt,
    output logic               shut_req,
    output logic               restart_req,
    output logic               fault_pin,
    output logic               sys_rst_n
);
    logic [RETRY_W-1:0] retry_d;
    logic [TMR_W-1:0]   tmr_q, tmr_d;
    logic [REL_W-1:0]   rel_q;
    logic               go_restart;
    logic               restart_q, fault_q;

    always_comb begin
        nxt        = state;
        retry_d    = retry_cnt;
        tmr_d      = tmr_q;
        go_restart = 1'b0;
        unique case (state)
            ST_WAIT, ST_RUN: begin
                if (any_evt) begin
                    if (!pol_retry || retry_cnt == RETRY_W'(RETRY_CAP)) begin
                        nxt = ST_LATCHED;
                    end else begin
                        nxt   = ST_BACKOFF;
                        tmr_d = '0;
                    end
                end else if (state == ST_WAIT && all_good) begin
                    nxt = ST_RUN;
                end
            end
            ST_BACKOFF: begin
                if (any_evt) begin
                    if (retry_cnt == RETRY_W'(RETRY_CAP - 1)) begin
                        nxt     = ST_LATCHED;
                        retry_d = RETRY_W'(RETRY_CAP);
                    end else begin
                        retry_d = retry_cnt + 1'b1;
                        tmr_d   = '0;
                    end
                end else if (tmr_q == TMR_W'(BACKOFF_CYC - 1)) begin
                    nxt        = ST_WAIT;
                    retry_d    = retry_cnt + 1'b1;
                    go_restart = 1'b1;
                end else begin
                    tmr_d = tmr_q + 1'b1;
                end
            end
            ST_LATCHED: begin
                if (man_clr) begin
                    nxt        = ST_WAIT;
                    go_restart = 1'b1;
                end
            end
        endcase
        if (man_clr) retry_d = '0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_WAIT;
            retry_cnt <= '0;
            tmr_q     <= '0;
        end else begin
            state     <= nxt;
            retry_cnt <= retry_d;
            tmr_q     <= tmr_d;
        end
    end

    // registered outputs and reset release delay
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            restart_q <= 1'b0;
            fault_q   <= 1'b0;
            rel_q     <= '0;
        end else begin
            restart_q <= go_restart;
            fault_q   <= any_evt;
            if (state != ST_RUN || !all_good || wdt_bark)
                rel_q <= '0;
            else if (rel_q != REL_W'(REL_CYC))
                rel_q <= rel_q + 1'b1;
        end
    end

    assign shut_req    = (state == ST_BACKOFF) || (state == ST_LATCHED);
    assign restart_req = restart_q;
    assign fault_pin   = fault_q;
    assign sys_rst_n   = (state == ST_RUN) && (rel_q == REL_W'(REL_CYC));
endmodule

// File: rtl/fpc_log.sv
module fpc_log
    import fpc_pkg::*;
#(
    parameter int N_RAILS = 4,
    parameter int CNT_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_RAILS-1:0]       evt,
    input  logic [2*N_RAILS-1:0]     kind,
    input  fpc_state_t               state,
    input  fpc_state_t               nxt,
    output logic [2*N_RAILS-1:0]     log_type,
    output logic [CNT_W*N_RAILS-1:0] log_count,
    output logic [2*N_RAILS-1:0]     log_status
);
    logic enter_latch, back_to_ok;

    assign enter_latch = (state != ST_LATCHED) && (nxt == ST_LATCHED);
    assign back_to_ok  = (state == ST_WAIT && nxt == ST_RUN) ||
                         (state == ST_LATCHED && nxt == ST_WAIT);

    for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
        logic [1:0]       type_q;
        logic [CNT_W-1:0] cnt_q;
        logic [1:0]       sts_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                type_q <= '0;
                cnt_q  <= '0;
                sts_q  <= STS_OK;
            end else if (evt[r]) begin
                type_q <= kind[2*r +: 2];
                if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
                sts_q  <= (nxt == ST_LATCHED) ? STS_LATCHED : STS_RETRY;
            end else if (enter_latch && sts_q == STS_RETRY) begin
                sts_q <= STS_LATCHED;
            end else if (back_to_ok) begin
                sts_q <= STS_OK;
            end
        end

        assign log_type[2*r +: 2]         = type_q;
        assign log_count[CNT_W*r +: CNT_W] = cnt_q;
        assign log_status[2*r +: 2]       = sts_q;
    end
endmodule

// File: rtl/fault_policy_ctrl.sv
module fault_policy_ctrl
    import fpc_pkg::*;
#(
    parameter int N_RAILS     = 4,
    parameter int CNT_W       = 4,
    parameter int MS_W        = 8,
    parameter int RETRY_CAP   = 3,
    parameter int BACKOFF_CYC = 1000,
    parameter int REL_CYC     = 200
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pol_retry,
    input  logic                     man_clr,
    input  logic                     wdt_bark,
    input  logic                     ms_tick,
    input  logic [N_RAILS-1:0]       rail_en,
    input  logic [N_RAILS-1:0]       rail_pg,
    input  logic [N_RAILS-1:0]       flt_ov,
    input  logic [2*N_RAILS-1:0]     flt_therm,
    input  logic [N_RAILS-1:0]       flt_uv,
    input  logic [N_RAILS-1:0]       flt_tmo,
    output logic                     shut_req,
    output logic                     restart_req,
    output logic                     fault_pin,
    output logic                     sys_rst_n,
    output logic [2*N_RAILS-1:0]     log_type,
    output logic [CNT_W*N_RAILS-1:0] log_count,
    output logic [2*N_RAILS-1:0]     log_status,
    output logic [MS_W*N_RAILS-1:0]  log_pg_ms
);
    localparam int RETRY_W = $clog2(RETRY_CAP + 1);

    logic [N_RAILS-1:0]   evt;
    logic [2*N_RAILS-1:0] kind;
    logic [RETRY_W-1:0]   retry_cnt;
    fpc_state_t           state, nxt;

    fpc_coalesce #(.N_RAILS(N_RAILS)) u_coalesce (
        .clk(clk), .rst_n(rst_n), .flt_ov(flt_ov), .flt_therm(flt_therm),
        .flt_uv(flt_uv), .flt_tmo(flt_tmo), .evt(evt), .kind(kind)
    );

    fpc_fsm #(
        .RETRY_CAP(RETRY_CAP), .BACKOFF_CYC(BACKOFF_CYC), .REL_CYC(REL_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .pol_retry(pol_retry), .man_clr(man_clr),
        .wdt_bark(wdt_bark), .all_good(&rail_pg), .any_evt(|evt),
        .state(state), .nxt(nxt), .retry_cnt(retry_cnt),
        .shut_req(shut_req), .restart_req(restart_req),
        .fault_pin(fault_pin), .sys_rst_n(sys_rst_n)
    );

    fpc_log #(.N_RAILS(N_RAILS), .CNT_W(CNT_W)) u_log (
        .clk(clk), .rst_n(rst_n), .evt(evt), .kind(kind), .state(state),
        .nxt(nxt), .log_type(log_type), .log_count(log_count),
        .log_status(log_status)
    );

    fpc_pgtime #(.N_RAILS(N_RAILS), .MS_W(MS_W)) u_pgtime (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .rail_en(rail_en),
        .rail_pg(rail_pg), .pg_ms(log_pg_ms)
    );
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
    parameter int N_RAILS   = 4,
    parameter int RETRY_CAP = 3,
    parameter int RETRY_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wdt_bark,
    input logic [N_RAILS-1:0] rail_pg,
    input logic               shut_req,
    input logic               restart_req,
    input logic               sys_rst_n,
    input logic [RETRY_W-1:0] retry_cnt
);
    assert_restart_after_shut_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> $past(shut_req));

    assert_shut_ends_in_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shut_req) |-> restart_req);

    assert_bark_holds_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_bark |=> !sys_rst_n);

    assert_release_needs_good_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_n |-> ($past(&rail_pg) && !shut_req));

    assert_retry_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        retry_cnt <= RETRY_W'(RETRY_CAP));
endmodule

bind fault_policy_ctrl fpc_checker #(
    .N_RAILS(N_RAILS), .RETRY_CAP(RETRY_CAP), .RETRY_W(RETRY_W)
) u_fpc_checker (
    .clk(clk), .rst_n(rst_n), .wdt_bark(wdt_bark), .rail_pg(rail_pg),
    .shut_req(shut_req), .restart_req(restart_req), .sys_rst_n(sys_rst_n),
    .retry_cnt(retry_cnt)
);

// File: tb/fault_policy_ctrl_bench.sv
module fault_policy_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NR  = 4;
    localparam int CW  = 2;
    localparam int MW  = 4;
    localparam int CAP = 2;
    localparam int BCK = 6;
    localparam int REL = 4;

    logic clk = 0, rst_n = 0;
    logic pol_retry = 0, man_clr = 0, wdt_bark = 0, ms_tick = 0;
    logic [NR-1:0] rail_en = '0, rail_pg = '0, flt_ov = '0, flt_uv = '0, flt_tmo = '0;
    logic [2*NR-1:0] flt_therm = '0;
    logic shut_req, restart_req, fault_pin, sys_rst_n;
    logic [2*NR-1:0] log_type, log_status;
    logic [CW*NR-1:0] log_count;
    logic [MW*NR-1:0] log_pg_ms;

    int n_checks = 0, n_fail = 0;
    bit done = 0, started = 0;

    fault_policy_ctrl #(
        .N_RAILS(NR), .CNT_W(CW), .MS_W(MW), .RETRY_CAP(CAP),
        .BACKOFF_CYC(BCK), .REL_CYC(REL)
    ) u_fault_policy_ctrl (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int  m_state, m_retry, m_tmr, m_rel;
    bit  m_fault, m_restart;
    int  m_type[NR], m_cnt[NR], m_sts[NR], m_pgms[NR], m_pgc[NR];
    bit  m_act_q[NR], m_pg_q[NR];
    int  ns, nr, nt;
    bit  rs, anyev, allg, act;
    bit  ev[NR];
    int  cause[NR];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_retry = 0; m_tmr = 0; m_rel = 0; m_fault = 0; m_restart = 0;
            for (int r = 0; r < NR; r++) begin
                m_type[r] = 0; m_cnt[r] = 0; m_sts[r] = 0; m_pgms[r] = 0;
                m_pgc[r] = 0; m_act_q[r] = 0; m_pg_q[r] = 0;
            end
        end else begin
            allg = &rail_pg;
            anyev = 0;
            for (int r = 0; r < NR; r++) begin
                act = flt_ov[r] || (flt_therm[2*r +: 2] >= 2) || flt_uv[r] || flt_tmo[r];
                ev[r] = act && !m_act_q[r];
                m_act_q[r] = act;
                cause[r] = flt_ov[r] ? 3 : (flt_therm[2*r +: 2] >= 2) ? 2 : flt_uv[r] ? 1 : 0;
                if (ev[r]) anyev = 1;
            end
            ns = m_state; nr = m_retry; nt = m_tmr; rs = 0;
            if (m_state <= 1) begin
                if (anyev) begin
                    if (!pol_retry || m_retry == CAP) ns = 3;
                    else begin ns = 2; nt = 0; end
                end else if (m_state == 0 && allg) ns = 1;
            end else if (m_state == 2) begin
                if (anyev) begin
                    if (m_retry + 1 == CAP) begin ns = 3; nr = CAP; end
                    else begin nr = m_retry + 1; nt = 0; end
                end else if (m_tmr == BCK - 1) begin
                    ns = 0; nr = m_retry + 1; rs = 1;
                end else nt = m_tmr + 1;
            end else if (man_clr) begin
                ns = 0; rs = 1;
            end
            if (man_clr) nr = 0;
            if (m_state != 1 || !allg || wdt_bark) m_rel = 0;
            else if (m_rel < REL) m_rel++;
            for (int r = 0; r < NR; r++) begin
                if (ev[r]) begin
                    m_type[r] = cause[r];
                    if (m_cnt[r] < (1 << CW) - 1) m_cnt[r]++;
                    m_sts[r] = (ns == 3) ? 1 : 2;
                end else if (m_state != 3 && ns == 3 && m_sts[r] == 2) m_sts[r] = 1;
                else if ((m_state == 0 && ns == 1) || (m_state == 3 && ns == 0)) m_sts[r] = 0;
                if (rail_en[r] && rail_pg[r] && !m_pg_q[r]) m_pgms[r] = m_pgc[r];
                if (!rail_en[r]) m_pgc[r] = 0;
                else if (!rail_pg[r] && ms_tick && m_pgc[r] < (1 << MW) - 1) m_pgc[r]++;
                m_pg_q[r] = rail_pg[r];
            end
            m_fault = anyev; m_restart = rs;
            m_state = ns; m_retry = nr; m_tmr = nt;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && rst_n && !done) begin
            int et, ec, es, ep;
            et = 0; ec = 0; es = 0; ep = 0;
            for (int r = 0; r < NR; r++) begin
                et |= m_type[r] << (2*r);
                ec |= m_cnt[r]  << (CW*r);
                es |= m_sts[r]  << (2*r);
                ep |= m_pgms[r] << (MW*r);
            end
            chk("R3 R4 shut_req", int'(shut_req), int'(m_state >= 2));
            chk("R4 restart_req", int'(restart_req), int'(m_restart));
            chk("R7 fault_pin", int'(fault_pin), int'(m_fault));
            chk("R10 sys_rst_n", int'(sys_rst_n), int'(m_state == 1 && m_rel == REL));
            chk("R1 log_type", int'(log_type), et);
            chk("R7 log_count", int'(log_count), ec);
            chk("R8 log_status", int'(log_status), es);
            chk("R9 log_pg_ms", int'(log_pg_ms), ep);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_uv(input int r);
        @(negedge clk) flt_uv[r] = 1;
        @(negedge clk) flt_uv[r] = 0;
    endtask

    task automatic count_shut(output int cnt);
        cnt = 0;
        for (int i = 0; i < 3*BCK; i++) begin
            if (shut_req) cnt++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int c;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        started = 1;
        // R12 reset state
        chk("R12 shut_req", int'(shut_req), 0);
        chk("R12 restart_req", int'(restart_req), 0);
        chk("R12 sys_rst_n", int'(sys_rst_n), 0);
        chk("R12 log_count", int'(log_count), 0);

        // R9 start-up timing
        rail_en = '1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk) ms_tick = 1;
            @(negedge clk) ms_tick = 0;
            if (k == 3)  rail_pg[0] = 1;
            if (k == 5)  rail_pg[1] = 1;
            if (k == 7)  rail_pg[2] = 1;
            if (k == 20) rail_pg[3] = 1;
        end
        step(2);
        chk("R9 pg time", int'(log_pg_ms), 3 | (5 << 4) | (7 << 8) | (15 << 12));

        // R10 release and watchdog
        step(REL + 2);
        chk("R10 released", int'(sys_rst_n), 1);
        @(negedge clk) wdt_bark = 1;
        @(negedge clk) wdt_bark = 0;
        chk("R10 bark", int'(sys_rst_n), 0);
        step(REL + 1);
        chk("R10 re-released", int'(sys_rst_n), 1);

        // R2 warning only
        @(negedge clk) flt_therm[3:2] = 2'd1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R2 warn no pulse", int'(fault_pin), 0);
        end
        flt_therm[3:2] = 2'd0;
        step(1);
        chk("R2 warn no log", int'(log_count), 0);
        chk("R2 warn no shut", int'(shut_req), 0);

        // R3 latch-off, R1 coalescing
        pol_retry = 0;
        @(negedge clk) begin flt_uv[2] = 1; flt_tmo[2] = 1; end
        @(negedge clk) begin flt_uv[2] = 0; flt_tmo[2] = 0; end
        chk("R7 pulse", int'(fault_pin), 1);
        chk("R3 shut", int'(shut_req), 1);
        chk("R1 uv over timeout", int'(log_type[5:4]), 1);
        step(10);
        chk("R3 held", int'(shut_req), 1);
        chk("R8 latched", int'(log_status[5:4]), 1);
        @(negedge clk) begin flt_ov[0] = 1; flt_therm[1:0] = 2'd2; end
        @(negedge clk) begin flt_ov[0] = 0; flt_therm[1:0] = 2'd0; end
        step(2);
        chk("R1 ov over thermal", int'(log_type[1:0]), 3);
        @(negedge clk) man_clr = 1;
        @(negedge clk) man_clr = 0;
        chk("R3 clear restart", int'(restart_req), 1);
        chk("R3 clear shut", int'(shut_req), 0);
        step(2);
        chk("R8 ok after clear", int'(log_status), 0);

        // R4 auto-retry
        pol_retry = 1;
        @(negedge clk) flt_therm[3:2] = 2'd2;
        @(negedge clk) flt_therm[3:2] = 2'd0;
        chk("R8 retrying", int'(log_status[3:2]), 2);
        count_shut(c);
        chk("R4 backoff length", c, BCK);
        chk("R8 ok after run", int'(log_status), 0);

        // R11 clear keeps counts
        @(negedge clk) man_clr = 1;
        @(negedge clk) man_clr = 0;
        chk("R11 counts kept", int'(log_count), 1 | (1 << 2) | (1 << 4));

        // R6 and R5
        rail_pg[3] = 0;
        pulse_uv(3);
        step(2);
        pulse_uv(3);
        count_shut(c);
        chk("R6 timer restarted", c, BCK);
        pulse_uv(3);
        step(3*BCK);
        chk("R5 capped latch", int'(shut_req), 1);
        chk("R5 status latched", int'(log_status[7:6]), 1);

        // R7 saturation
        for (int i = 0; i < 4; i++) begin
            pulse_uv(0);
            step(1);
        end
        chk("R7 saturated", int'(log_count[1:0]), 3);
        step(3);
        finish_run();
    end
endmodule